// File: doc/BRIEF.md
# Privilege-Level State Access Gate

This block rules on every access that reaches extension state guarded by the per-level state-enable vectors. The instruction decoder supplies three things: a request strobe, the hart's current privilege mode, and the index of the gated state class being touched. The CSR file supplies the effective enable vectors for the machine, hypervisor and supervisor levels. In the same cycle, the block answers with an allow bit or a trap cause.

An enable bit restricts only modes below the level that owns it. A request is therefore checked against the AND of the matching bits from every level above the current mode. Machine mode passes every check.

When a denial happens in a virtualized mode, the trap cause depends on which level blocked the access. A cleared machine-level bit always gives illegal-instruction. A cleared hypervisor-level or supervisor-level bit, with the machine-level bit set, gives virtual-instruction. The topmost class index stands for the lower-level state-enable registers themselves, so guest code cannot reach those registers unless the level above has granted that access.

Top module: `state_access_gate`

## Requirements
- R1: While `req_valid` is 0, `allow` is 0 and `trap_kind` is 0 (none), whatever the other inputs are.
- R2: Mode code 0 is machine mode. A valid request in machine mode is always allowed, with `trap_kind` 0, even when all three enable vectors are zero.
- R3: Mode code 1 is supervisor mode (HS or S). Only the machine-level bit of the class is checked; the hypervisor and supervisor vectors have no effect. A denial gives `trap_kind` 1 (illegal-instruction).
- R4: Mode code 2 is user mode. The machine-level and supervisor-level bits are both required, and the hypervisor vector has no effect. Every denial gives `trap_kind` 1.
- R5: Mode code 3 is virtualized supervisor mode. The machine-level and hypervisor-level bits are both required, and the supervisor vector has no effect.
- R6: Mode code 4 is virtualized user mode. The machine-level, hypervisor-level and supervisor-level bits are all required.
- R7: In any mode other than machine mode, a cleared machine-level bit gives `trap_kind` 1, including in modes 3 and 4.
- R8: `trap_kind` 2 (virtual-instruction) appears only in modes 3 and 4. It appears only when the machine-level bit is set and a hypervisor-level or supervisor-level bit blocks the access.
- R9: A request looks only at bit `cls_idx` of each vector; every other bit has no effect. Index `NUM_CLASSES-1` denotes the lower-level state-enable registers, which are gated by the same rules.
- R10: For mode codes 5 to 7, a valid request is denied with `trap_kind` 1.
- R11: At most one of the following holds: `allow` is 1, or `trap_kind` is nonzero. A valid request always produces exactly one of them. Both outputs settle in the same cycle as the request, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | Access to gated state is being attempted |
| priv_mode | input | 3 | Current mode: 0 M, 1 S/HS, 2 U, 3 VS, 4 VU |
| cls_idx | input | $clog2(NUM_CLASSES) | Gated state class; top index means lower enable registers |
| m_en | input | NUM_CLASSES | Effective machine-level enable vector |
| h_en | input | NUM_CLASSES | Effective hypervisor-level enable vector |
| s_en | input | NUM_CLASSES | Effective supervisor-level enable vector |
| allow | output | 1 | Access may proceed |
| trap_kind | output | 2 | 0 none, 1 illegal-instruction, 2 virtual-instruction |

## Verification
No register sits between any input and either output, so each result is due in the same cycle as its stimulus, after zero clock edges. The bench drives every stimulus on the falling clock edge. It samples `allow` and `trap_kind` a few nanoseconds later, well before the next rising edge, so the comparison never races a clock edge. Each scenario task pairs its own stimulus with the expected values it computes, then moves on to the next stimulus.

// File: rtl/state_access_gate.sv
module state_access_gate #(
  parameter int NUM_CLASSES = 64,
  localparam int IW = $clog2(NUM_CLASSES)
) (
  input  logic                   req_valid,
  input  logic [2:0]             priv_mode,
  input  logic [IW-1:0]          cls_idx,
  input  logic [NUM_CLASSES-1:0] m_en,
  input  logic [NUM_CLASSES-1:0] h_en,
  input  logic [NUM_CLASSES-1:0] s_en,
  output logic                   allow,
  output logic [1:0]             trap_kind
);

  localparam logic [2:0] MODE_M  = 3'd0;
  localparam logic [2:0] MODE_S  = 3'd1;
  localparam logic [2:0] MODE_U  = 3'd2;
  localparam logic [2:0] MODE_VS = 3'd3;
  localparam logic [2:0] MODE_VU = 3'd4;

  localparam logic [1:0] TRAP_NONE = 2'd0;
  localparam logic [1:0] TRAP_ILL  = 2'd1;
  localparam logic [1:0] TRAP_VIRT = 2'd2;

  logic bit_m, bit_h, bit_s;
  logic known_mode, virt;
  logic need_m, need_h, need_s;
  logic pass_m, pass_lower, granted;

  assign bit_m = m_en[cls_idx];
  assign bit_h = h_en[cls_idx];
  assign bit_s = s_en[cls_idx];

  assign known_mode = (priv_mode <= MODE_VU);
  assign virt       = (priv_mode == MODE_VS) || (priv_mode == MODE_VU);

  assign need_m = known_mode && (priv_mode != MODE_M);
  assign need_h = virt;
  assign need_s = (priv_mode == MODE_U) || (priv_mode == MODE_VU);

  assign pass_m     = !need_m || bit_m;
  assign pass_lower = (!need_h || bit_h) && (!need_s || bit_s);
  assign granted    = known_mode && pass_m && pass_lower;

  assign allow = req_valid && granted;

  always_comb begin
    trap_kind = TRAP_NONE;
    if (req_valid && !granted) begin
      if (!known_mode || !pass_m || !virt) trap_kind = TRAP_ILL;
      else                                 trap_kind = TRAP_VIRT;
    end
  end

  always_comb begin
    AST_IDLE_QUIET: assert (req_valid || (!allow && trap_kind == TRAP_NONE)); // R1
    AST_MACHINE_FREE: assert (!(req_valid && priv_mode == MODE_M) || allow); // R2
    AST_MBIT_ILLEGAL: assert (!(req_valid && priv_mode != MODE_M && !m_en[cls_idx])
                              || trap_kind == TRAP_ILL); // R7
    AST_VIRT_SOURCE: assert (trap_kind != TRAP_VIRT ||
                             ((priv_mode == MODE_VS || priv_mode == MODE_VU) && m_en[cls_idx])); // R8
    AST_RESERVED_DENY: assert (!(req_valid && priv_mode > MODE_VU) || trap_kind == TRAP_ILL); // R10
    AST_ONE_OUTCOME: assert (!(allow && trap_kind != TRAP_NONE) &&
                             (!req_valid || allow || trap_kind != TRAP_NONE)); // R11
    AST_CODE_RANGE: assert (trap_kind != 2'd3); // R11
  end

endmodule

// File: tb/state_access_gate_tb.sv
module state_access_gate_tb;
  localparam int N  = 64;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          req_valid;
  logic [2:0]    priv_mode;
  logic [IW-1:0] cls_idx;
  logic [N-1:0]  m_en, h_en, s_en;
  logic          allow;
  logic [1:0]    trap_kind;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  state_access_gate #(.NUM_CLASSES(N)) u_dut (
    .req_valid(req_valid), .priv_mode(priv_mode), .cls_idx(cls_idx),
    .m_en(m_en), .h_en(h_en), .s_en(s_en),
    .allow(allow), .trap_kind(trap_kind)
  );

  task automatic apply(input logic v, input logic [2:0] md, input int idx,
                       input logic mb, input logic hb, input logic sb);
    @(negedge clk);
    req_valid = v;
    priv_mode = md;
    cls_idx   = IW'(idx);
    m_en = '1; h_en = '1; s_en = '1;
    m_en[idx] = mb; h_en[idx] = hb; s_en[idx] = sb;
    #3;
  endtask

  task automatic expect_out(input string req, input logic ea, input logic [1:0] et);
    compared++;
    if (allow !== ea || trap_kind !== et) begin
      mismatched++;
      $display("FAIL %s: allow=%0b trap=%0d expected allow=%0b trap=%0d",
               req, allow, trap_kind, ea, et);
    end
  endtask

  task automatic t_idle;
    apply(0, 3'd4, 5, 0, 0, 0); expect_out("R1", 0, 2'd0);
    apply(0, 3'd0, 0, 1, 1, 1); expect_out("R1", 0, 2'd0);
  endtask

  task automatic t_machine;
    apply(1, 3'd0, 7, 0, 0, 0); expect_out("R2", 1, 2'd0);
    @(negedge clk); m_en = '0; h_en = '0; s_en = '0; #3;
    expect_out("R2", 1, 2'd0);
  endtask

  task automatic t_super;
    apply(1, 3'd1, 3, 1, 0, 0); expect_out("R3", 1, 2'd0);
    apply(1, 3'd1, 3, 0, 1, 1); expect_out("R3", 0, 2'd1);
  endtask

  task automatic t_user;
    apply(1, 3'd2, 2, 1, 0, 1); expect_out("R4", 1, 2'd0);
    apply(1, 3'd2, 2, 1, 1, 0); expect_out("R4", 0, 2'd1);
    apply(1, 3'd2, 2, 0, 1, 1); expect_out("R4", 0, 2'd1);
  endtask

  task automatic t_vs;
    apply(1, 3'd3, 9, 1, 1, 0); expect_out("R5", 1, 2'd0);
    apply(1, 3'd3, 9, 1, 0, 1); expect_out("R5", 0, 2'd2);
  endtask

  task automatic t_vu;
    apply(1, 3'd4, 11, 1, 1, 1); expect_out("R6", 1, 2'd0);
    apply(1, 3'd4, 11, 1, 1, 0); expect_out("R6", 0, 2'd2);
    apply(1, 3'd4, 11, 1, 0, 1); expect_out("R6", 0, 2'd2);
  endtask

  task automatic t_priority;
    apply(1, 3'd3, 4, 0, 0, 0); expect_out("R7", 0, 2'd1);
    apply(1, 3'd4, 4, 0, 0, 0); expect_out("R7", 0, 2'd1);
    apply(1, 3'd4, 4, 0, 1, 1); expect_out("R7", 0, 2'd1);
    apply(1, 3'd2, 4, 1, 0, 0); expect_out("R8", 0, 2'd1);
    apply(1, 3'd1, 4, 0, 0, 0); expect_out("R8", 0, 2'd1);
  endtask

  task automatic t_index;
    apply(1, 3'd4, N-1, 1, 1, 1); expect_out("R9", 1, 2'd0);
    apply(1, 3'd4, N-1, 1, 0, 1); expect_out("R9", 0, 2'd2);
    apply(1, 3'd2, N-1, 0, 1, 1); expect_out("R9", 0, 2'd1);
    @(negedge clk);
    req_valid = 1; priv_mode = 3'd4; cls_idx = '0;
    m_en = '0; h_en = '0; s_en = '0;
    m_en[0] = 1; h_en[0] = 1; s_en[0] = 1;
    #3; expect_out("R9", 1, 2'd0);
    @(negedge clk);
    m_en = '1; h_en = '1; s_en = '1;
    m_en[0] = 0;
    #3; expect_out("R9", 0, 2'd1);
  endtask

  task automatic t_reserved;
    for (int md = 5; md < 8; md++) begin
      apply(1, 3'(md), 1, 1, 1, 1); expect_out("R10", 0, 2'd1);
    end
  endtask

  task automatic t_sameslot;
    apply(1, 3'd3, 6, 1, 1, 1);
    expect_out("R11", 1, 2'd0);
    @(negedge clk); h_en[6] = 0; #1;
    expect_out("R11", 0, 2'd2);
  endtask

  initial begin
    for (int c = 0; c < 2000; c++) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    req_valid = 0; priv_mode = 0; cls_idx = '0;
    m_en = '0; h_en = '0; s_en = '0;
    #3;
    expect_out("R1", 0, 2'd0);
    t_idle();
    t_machine();
    t_super();
    t_user();
    t_vs();
    t_vu();
    t_priority();
    t_index();
    t_reserved();
    t_sameslot();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule